// File: doc/BRIEF.md
# SMBus Master Status Tracker

This block keeps the status flags of a two-wire serial bus master that sits inside a memory controller. Two requesters share the bus engine: a software path that issues manual read and write commands, and a hardware sequencer that polls a set of temperature sensors in turn. The tracker decides which request starts next. It records whether read data is valid, whether a write has finished, whether any transfer was refused, and whether a transfer is in flight. It also tells the poll sequencer whether polling is allowed and which sensor comes next.

The bit-level engine reports the end of each transfer. A normal completion is one event, and a refusal at the acknowledge slot is another. A separate message-channel path can also report a refusal. A refusal stops hardware polling and freezes the sensor index until software issues its next command. A soft-reset request aborts the transfer in flight. There are two resets. A cold reset clears everything. A warm reset clears everything except the in-flight state, so after a surprise warm reset software can see that a slave may still be holding the bus.

Top module: `smb_status_tracker`

## Requirements
- R1: After cold reset, busy, read-valid, write-done and error are 0, the sensor index is 0 and polling is enabled.
- R2: A manual read request while idle produces start kind 1 in that cycle. Busy is 1 and read-valid is 0 from the next cycle. A normal completion of that read then clears busy and sets read-valid.
- R3: A manual write request while idle produces start kind 2 in that cycle. Busy is 1 and write-done is 0 from the next cycle. A normal completion of that write then clears busy and sets write-done.
- R4: A refusal from the engine during a transfer sets the error flag and clears busy. A refusal from the message channel sets the error flag at any time.
- R5: While the error flag is 1, polling-enable is 0 and no poll is started (start kind 3 never appears). A poll that completes while the error flag is 1 leaves the sensor index unchanged.
- R6: A manual command is accepted regardless of the error flag, and accepting it clears the error flag. If a refusal arrives in the same cycle, the error flag is set instead.
- R7: No request is started while busy is 1 (start kind stays 0).
- R8: When requests coincide while idle, a manual read wins over a manual write, and any manual command wins over a poll.
- R9: A normal poll completion while error is 0 advances the sensor index by one. After sensor NUM_SENS-1 the index returns to 0.
- R10: Soft reset clears busy on the next cycle and blocks any start in its own cycle.
- R11: A warm reset clears read-valid, write-done, error and the sensor index, but leaves busy unchanged. A later completion of the interrupted transfer still finishes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| man_rd_go | input | 1 | Manual read request |
| man_wr_go | input | 1 | Manual write request |
| poll_req | input | 1 | Poll sequencer requests a sensor read |
| eng_done | input | 1 | Engine: transfer completed normally |
| eng_nack | input | 1 | Engine: no acknowledge at the expected slot |
| msg_nack | input | 1 | Message-channel transfer was refused |
| soft_rst | input | 1 | Soft reset of the bus master |
| start_kind | output | 2 | Transfer started this cycle: 0 none, 1 read, 2 write, 3 poll |
| busy | output | 1 | A transfer is in flight |
| rd_valid | output | 1 | Read data valid |
| wr_done | output | 1 | Write finished |
| err | output | 1 | Error flag |
| poll_en | output | 1 | Hardware polling allowed |
| idx_adv | output | 1 | Sensor index advances this cycle |
| slave_idx | output | IDX_W | Sensor to poll next |

## Verification
The error flag has two actions that can fall in the same cycle. A manual command clears it, and a refusal sets it. The bench provokes this by raising a write request and a message-channel refusal on the same edge while idle. It expects the write to start, write-done to clear, and error to read 1 afterwards. A second overlap has a poll in flight when a refusal arrives, followed by the poll's normal completion. Here the bench expects the sensor index to stay where it was.

// File: rtl/smb_trk_pkg.sv
package smb_trk_pkg;
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_RD   = 2'd1,
        KIND_WR   = 2'd2,
        KIND_POLL = 2'd3
    } kind_e;
endpackage

// File: rtl/smb_trk_arb.sv
module smb_trk_arb
    import smb_trk_pkg::*;
(
    input  logic  busy,
    input  logic  hold,
    input  logic  err,
    input  logic  man_rd,
    input  logic  man_wr,
    input  logic  poll,
    output kind_e grant
);
    // Fixed priority: read, write, then poll (poll only when no error)
    always_comb begin
        grant = KIND_NONE;
        if (!busy && !hold) begin
            if (man_rd)           grant = KIND_RD;
            else if (man_wr)      grant = KIND_WR;
            else if (poll && !err) grant = KIND_POLL;
        end
    end
endmodule

// File: rtl/smb_trk_idx.sv
module smb_trk_idx #(
    parameter int NUM_SENS = 3,
    parameter int IDX_W    = 2
) (
    input  logic [IDX_W-1:0] cur,
    output logic [IDX_W-1:0] nxt
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SENS - 1);

    generate
        if ((1 << IDX_W) == NUM_SENS) begin : g_pow2
            assign nxt = cur + 1'b1;
        end else begin : g_cmp
            assign nxt = (cur == LAST) ? '0 : cur + 1'b1;
        end
    endgenerate
endmodule

// File: rtl/smb_status_tracker.sv
module smb_status_tracker
    import smb_trk_pkg::*;
#(
    parameter int NUM_SENS = 3,
    parameter int IDX_W    = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
    input  logic             clk,
    input  logic             cold_rst_n,
    input  logic             warm_rst_n,
    input  logic             man_rd_go,
    input  logic             man_wr_go,
    input  logic             poll_req,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic             msg_nack,
    input  logic             soft_rst,
    output logic [1:0]       start_kind,
    output logic             busy,
    output logic             rd_valid,
    output logic             wr_done,
    output logic             err,
    output logic             poll_en,
    output logic             idx_adv,
    output logic [IDX_W-1:0] slave_idx
);
    typedef struct packed {
        logic             busy;
        kind_e            kind;
        logic             rdv;
        logic             wrd;
        logic             err;
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t              st_d, st_q;
    kind_e            grant;
    logic [IDX_W-1:0] idx_nxt;
    logic             end_ok, end_bad, adv;

    smb_trk_arb u_arb (
        .busy   (st_q.busy),
        .hold   (soft_rst),
        .err    (st_q.err),
        .man_rd (man_rd_go),
        .man_wr (man_wr_go),
        .poll   (poll_req),
        .grant  (grant)
    );

    smb_trk_idx #(.NUM_SENS(NUM_SENS), .IDX_W(IDX_W)) u_idx (
        .cur (st_q.idx),
        .nxt (idx_nxt)
    );

    always_comb begin
        st_d    = st_q;
        end_ok  = st_q.busy && eng_done && !eng_nack;
        end_bad = st_q.busy && eng_nack;
        adv     = end_ok && (st_q.kind == KIND_POLL) && !st_q.err;

        if (end_ok || end_bad) begin
            st_d.busy = 1'b0;
            st_d.kind = KIND_NONE;
        end
        if (end_ok && st_q.kind == KIND_RD) st_d.rdv = 1'b1;
        if (end_ok && st_q.kind == KIND_WR) st_d.wrd = 1'b1;
        if (adv) st_d.idx = idx_nxt;

        if (grant != KIND_NONE) begin
            st_d.busy = 1'b1;
            st_d.kind = grant;
            if (grant == KIND_RD)   st_d.rdv = 1'b0;
            if (grant == KIND_WR)   st_d.wrd = 1'b0;
            if (grant != KIND_POLL) st_d.err = 1'b0;
        end

        if (end_bad || msg_nack) st_d.err = 1'b1;

        if (soft_rst) begin
            st_d.busy = 1'b0;
            st_d.kind = KIND_NONE;
        end
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            st_q <= '0;
        end else if (!warm_rst_n) begin
            st_q.rdv <= 1'b0;
            st_q.wrd <= 1'b0;
            st_q.err <= 1'b0;
            st_q.idx <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_kind = grant;
    assign busy       = st_q.busy;
    assign rd_valid   = st_q.rdv;
    assign wr_done    = st_q.wrd;
    assign err        = st_q.err;
    assign poll_en    = !st_q.err;
    assign idx_adv    = adv;
    assign slave_idx  = st_q.idx;
endmodule

// File: rtl/smb_status_tracker_chk.sv
module smb_status_tracker_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             cold_rst_n,
    input logic             warm_rst_n,
    input logic             soft_rst,
    input logic             eng_nack,
    input logic [1:0]       start_kind,
    input logic             busy,
    input logic             rd_valid,
    input logic             err,
    input logic             poll_en,
    input logic             idx_adv,
    input logic [IDX_W-1:0] slave_idx
);
    // R7
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        busy |-> start_kind == 2'd0);

    // R2
    rd_start_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        start_kind == 2'd1 |=> busy && !rd_valid);

    // R4
    nack_err_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        (eng_nack && busy) |=> err && !busy);

    // R5
    err_gate_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        err |-> !poll_en && start_kind != 2'd3 && !idx_adv);

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        soft_rst |=> !busy);

    // R9
    idx_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        !idx_adv |=> $stable(slave_idx));

    // R11
    warm_keep_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_rst_n |=> busy == $past(busy) && !err);
endmodule

bind smb_status_tracker smb_status_tracker_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .soft_rst   (soft_rst),
    .eng_nack   (eng_nack),
    .start_kind (start_kind),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .err        (err),
    .poll_en    (poll_en),
    .idx_adv    (idx_adv),
    .slave_idx  (slave_idx)
);

// File: tb/smb_status_tracker_test.sv
module smb_status_tracker_test;
    logic       clk = 1'b0;
    logic       cold_rst_n = 1'b0, warm_rst_n = 1'b1;
    logic       man_rd_go = 0, man_wr_go = 0, poll_req = 0;
    logic       eng_done = 0, eng_nack = 0, msg_nack = 0, soft_rst = 0;
    logic [1:0] start_kind;
    logic       busy, rd_valid, wr_done, err, poll_en, idx_adv;
    logic [1:0] slave_idx;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    smb_status_tracker #(.NUM_SENS(3)) uut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .man_rd_go(man_rd_go), .man_wr_go(man_wr_go), .poll_req(poll_req),
        .eng_done(eng_done), .eng_nack(eng_nack), .msg_nack(msg_nack),
        .soft_rst(soft_rst), .start_kind(start_kind), .busy(busy),
        .rd_valid(rd_valid), .wr_done(wr_done), .err(err), .poll_en(poll_en),
        .idx_adv(idx_adv), .slave_idx(slave_idx)
    );

    // [14]rd [13]wr [12]poll [11]done [10]nack [9]msg [8]soft
    // [7:6]start kind  [5]busy [4]rd_valid [3]wr_done [2]err [1:0]idx
    localparam int NV = 21;
    localparam logic [14:0] TBL [NV] = '{
        15'b1000000_01_1000_00, // R2 read start
        15'b0000000_00_1000_00, // R7 idle while busy
        15'b0001000_00_0100_00, // R2 read done
        15'b0100000_10_1100_00, // R3 write start
        15'b0001000_00_0110_00, // R3 write done
        15'b0010000_11_1110_00, // R9 poll start
        15'b0001000_00_0110_01, // R9 poll done, idx 1
        15'b1010000_01_1010_01, // R8 manual over poll
        15'b0010000_00_1010_01, // R7 poll blocked by busy
        15'b0000100_00_0011_01, // R4 nack
        15'b0010000_00_0011_01, // R5 poll blocked by error
        15'b0100000_10_1000_01, // R6 write clears error
        15'b0001000_00_0010_01, // R3 done
        15'b0010000_11_1010_01, // R9 poll
        15'b0001000_00_0010_10, // R9 idx 2
        15'b0010000_11_1010_10, // R9 poll
        15'b0001000_00_0010_00, // R9 wrap to 0
        15'b1100000_01_1010_00, // R8 read over write
        15'b0000001_00_0010_00, // R10 soft reset
        15'b0100010_10_1001_00, // R6 set wins over clear
        15'b0001000_00_0011_00  // R3 done, error kept
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic regs(input string req, input logic b, input logic r,
                        input logic w, input logic e, input logic [1:0] ix);
        chk(req, {busy, rd_valid, wr_done, err, slave_idx},
                 {b, r, w, e, ix});
    endtask

    task automatic drive(input logic [6:0] v);
        {man_rd_go, man_wr_go, poll_req, eng_done, eng_nack, msg_nack, soft_rst} = v;
    endtask

    task automatic step(input logic [6:0] v);
        drive(v);
        @(negedge clk);
        drive(7'b0);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        cold_rst_n = 1'b1;
        @(negedge clk);
        // R1
        regs("R1 reset", 0, 0, 0, 0, 2'd0);
        chk("R1 poll_en", poll_en, 1);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][14:8]);
            #1;
            chk($sformatf("row%0d start", i), start_kind, TBL[i][7:6]);
            @(negedge clk);
            drive(7'b0);
            chk($sformatf("row%0d flags", i), {busy, rd_valid, wr_done, err, slave_idx},
                TBL[i][5:0]);
        end

        // R5: error flag drops polling enable
        chk("R5 poll_en", poll_en, 0);

        // R11: warm reset during a read keeps busy
        step(7'b1000000);               // read start, error cleared
        step(7'b0000010);               // message-channel refusal
        regs("R4 msg nack", 1, 0, 1, 1, 2'd0);
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        regs("R11 warm keeps busy", 1, 0, 0, 0, 2'd0);
        step(7'b0001000);
        regs("R11 completion after warm", 0, 1, 0, 0, 2'd0);

        // R5: refusal during a poll freezes the index
        step(7'b0010000);
        step(7'b0010000);               // advance to idx 1 needs done
        step(7'b0001000);
        regs("R9 idx 1", 0, 1, 0, 0, 2'd1);
        step(7'b0010000);
        step(7'b0000010);
        regs("R5 err in poll", 1, 1, 0, 1, 2'd1);
        drive(7'b0001000);
        #1;
        chk("R5 no idx_adv", idx_adv, 0);
        @(negedge clk);
        drive(7'b0);
        regs("R5 idx frozen", 0, 1, 0, 1, 2'd1);

        // R10: soft reset blocks a start in its own cycle
        drive(7'b1000001);
        #1;
        chk("R10 no start", start_kind, 0);
        @(negedge clk);
        drive(7'b0);
        regs("R10 blocked", 0, 1, 0, 1, 2'd1);

        // R1: cold reset clears busy as well
        step(7'b0100000);
        cold_rst_n = 1'b0;
        #1;
        regs("R1 cold", 0, 0, 0, 0, 2'd0);
        @(negedge clk);
        cold_rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule